// File: doc/BRIEF.md
# Receive Frame Buffer with Error Filtering

This block buffers bytes arriving from a MAC receive path and hands them to a DMA-side reader one frame at a time. The writer marks each byte with start-of-frame and end-of-frame and, on the end byte, two error flags: a general error and a payload-checksum-only error. The block decides for every frame whether to keep or discard it. Kept frames reach the reader as a byte stream with a last marker. Alongside that stream runs a status queue that holds one entry per delivered frame, with its length and error marks.

Forwarding has two modes. In store-and-forward mode a frame becomes visible only after its last byte has been written. In cut-through mode bytes become visible as soon as the frame has collected a programmable number of bytes. A frame that is dropped gives back its space by rewinding the write pointer to the frame's first address. A descriptor-unavailable input can flush every complete frame the reader has not yet started on. The receive input has no back-pressure, because a MAC cannot pause. When the buffer is full, the rest of the frame is cut off and the frame is marked as errored. The byte output and the status output are valid/ready streams. Each holds its word steady until it is accepted, and a flush is the only event that withdraws a word.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset, `out_valid` and `sts_valid` are low.
- R2: With `cfg_store_fwd`=1, no byte of a frame is offered before its end byte has been written. Bytes come out in arrival order, and `out_last`=1 marks only the final byte.
- R3: With `cfg_store_fwd`=0, a frame starts forwarding in the cycle after its Nth byte is written, where N = THR_UNIT*(`cfg_thr_sel`+1). This gives 32, 64, 96 and 128 bytes by default. The frame is not forwarded before that byte, unless its end byte comes first. Mode and threshold are sampled when a frame starts.
- R4: A frame that has not started forwarding and carries an error, while `cfg_fwd_err`=0, is dropped at its end byte. It produces no output bytes and no status entry, and its space is reused by the next frame. This applies in both modes.
- R5: With `cfg_keep_csum`=1, a frame whose only error is `in_csum_err` is kept. With `cfg_keep_csum`=0, such a frame is dropped when `cfg_fwd_err`=0. A frame that has both error flags set is always dropped when `cfg_fwd_err`=0.
- R6: With `cfg_fwd_err`=1, error frames are kept, and their status carries the error marks.
- R7: In cut-through mode, a frame that has already started forwarding is delivered in full even if it ends with an error. Its status then has `sts_err`=1.
- R8: A non-final byte is stored only while fewer than DEPTH-1 bytes are held, and the end byte is always stored. Once a byte is refused, the rest of the frame up to its end byte is discarded and the frame counts as a general error. Occupancy never exceeds DEPTH.
- R9: When `desc_unavail`=1, `cfg_flush_dis`=0 and the reader is at a frame boundary, all complete frames are flushed in one cycle, together with their status entries. In the following cycle `sts_valid` is low.
- R10: With `cfg_flush_dis`=1, `desc_unavail` has no effect.
- R11: A frame whose start byte arrives while the status queue holds STS_DEPTH entries is discarded entirely.
- R12: A status entry has `sts_len` equal to the number of stored bytes, `sts_err` equal to the general error or truncation, and `sts_csum` equal to the checksum flag. The entry stays stable while `sts_valid`=1 and `sts_ready`=0.
- R13: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_store_fwd | input | 1 | 1 = store-and-forward, 0 = cut-through |
| cfg_thr_sel | input | 2 | Cut-through threshold select |
| cfg_fwd_err | input | 1 | 1 = keep error frames |
| cfg_keep_csum | input | 1 | 1 = keep checksum-only error frames |
| cfg_flush_dis | input | 1 | 1 = ignore descriptor-unavailable |
| desc_unavail | input | 1 | No receive descriptor available |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | General error, qualified by in_eof |
| in_csum_err | input | 1 | Payload checksum error, qualified by in_eof |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Reader accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| sts_valid | output | 1 | Status entry available |
| sts_ready | input | 1 | Reader accepts status |
| sts_len | output | $clog2(DEPTH)+1 | Stored frame length in bytes |
| sts_err | output | 1 | Frame had a general error or was truncated |
| sts_csum | output | 1 | Frame had a checksum error |

## Verification
The bench builds the block with DEPTH=64, STS_DEPTH=4 and THR_UNIT=8. A 64-byte buffer lets an 80-byte frame overflow within a short run. Four status slots let a fifth small frame hit the full status queue. A threshold unit of 8 bytes puts the cut-through start point at 16 bytes, so the bench can probe both sides of it with frames of about 20 bytes.

// File: rtl/rxff_pkg.sv
package rxff_pkg;

  // end-of-frame error marks
  typedef struct packed {
    logic gen_err;
    logic csum_err;
  } rxff_flags_t;

  // keep/drop decision taken on the end byte of a frame
  function automatic logic rxff_keep(input rxff_flags_t f, input logic started,
                                     input logic fwd_all, input logic keep_csum);
    if (started || fwd_all) return 1'b1;
    if (!f.gen_err && !f.csum_err) return 1'b1;
    return keep_csum && !f.gen_err;
  endfunction

  // cut-through start threshold in bytes
  function automatic int unsigned rxff_thr(input int unsigned unit, input logic [1:0] sel);
    return unit * (int'(sel) + 1);
  endfunction

endpackage

// File: rtl/rxff_ram.sv
module rxff_ram #(
  parameter int DW = 9,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxff_sts_q.sv
module rxff_sts_q #(
  parameter int W = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wp, rp;
  logic          do_push;

  assign count   = wp - rp;
  assign valid   = (count != '0);
  assign dout    = mem[rp[AW-1:0]];
  assign do_push = push && !clr && (count < CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      rp <= wp;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (pop && valid) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/rxff_wr_ctrl.sv
module rxff_wr_ctrl
  import rxff_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int STS_DEPTH = 64,
  parameter int THR_UNIT = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(STS_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic          in_csum_err,
  input  logic          cfg_store_fwd,
  input  logic [1:0]    cfg_thr_sel,
  input  logic          cfg_fwd_err,
  input  logic          cfg_keep_csum,
  input  logic [PW-1:0] rd_ptr,
  input  logic [CW-1:0] sts_cnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [8:0]    mem_wdata,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] commit_ptr,
  output logic [PW-1:0] done_ptr,
  output logic [PW-1:0] push_end,
  output logic          sts_push,
  output logic [PW-1:0] sts_len,
  output logic          sts_err,
  output logic          sts_csum
);
  // per-frame state, valid while in_frame
  logic          in_frame, skip_q, trunc_q, started_q, sf_q;
  logic [1:0]    sel_q;
  logic [PW-1:0] start_q, cnt_q;
  // frame state seen by the current beat
  logic          cur_skip, cur_trunc, cur_started, cur_sf;
  logic [1:0]    cur_sel;
  logic [PW-1:0] cur_start, cur_cnt;
  logic          beat, room, wr_en, trunc_n, started_n, keep, drop_end;
  logic [PW-1:0] used, cnt_n, wr_next;
  rxff_flags_t   flags;

  always_comb begin
    beat = in_valid && (in_frame || in_sof);
    if (in_frame) begin
      cur_skip = skip_q;   cur_trunc = trunc_q; cur_started = started_q;
      cur_sf   = sf_q;     cur_sel   = sel_q;   cur_start   = start_q;
      cur_cnt  = cnt_q;
    end else begin
      cur_skip = (sts_cnt >= CW'(STS_DEPTH));
      cur_trunc = 1'b0;    cur_started = 1'b0;
      cur_sf   = cfg_store_fwd; cur_sel = cfg_thr_sel; cur_start = wr_ptr;
      cur_cnt  = '0;
    end
    used      = wr_ptr - rd_ptr;
    // one slot is always held back for the end byte
    room      = in_eof ? (used < PW'(DEPTH)) : (used < PW'(DEPTH - 1));
    wr_en     = beat && !cur_skip && room && (in_eof || !cur_trunc);
    trunc_n   = cur_trunc || (beat && !cur_skip && !in_eof && !room);
    cnt_n     = cur_cnt + PW'(wr_en);
    wr_next   = wr_ptr + PW'(wr_en);
    started_n = cur_started ||
                (!cur_sf && wr_en && !in_eof && (32'(cnt_n) >= rxff_thr(THR_UNIT, cur_sel)));
    flags.gen_err  = in_err || trunc_n;
    flags.csum_err = in_csum_err;
    keep      = rxff_keep(flags, started_n, cfg_fwd_err, cfg_keep_csum);
    sts_push  = beat && in_eof && !cur_skip && keep;
    drop_end  = beat && in_eof && !cur_skip && !keep;
  end

  assign mem_we    = wr_en;
  assign mem_addr  = wr_ptr[AW-1:0];
  assign mem_wdata = {in_eof, in_data};
  assign push_end  = wr_next;
  assign sts_len   = cnt_n;
  assign sts_err   = flags.gen_err;
  assign sts_csum  = flags.csum_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; skip_q <= 1'b0; trunc_q <= 1'b0; started_q <= 1'b0;
      sf_q <= 1'b1; sel_q <= '0; start_q <= '0; cnt_q <= '0;
      wr_ptr <= '0; commit_ptr <= '0; done_ptr <= '0;
    end else if (beat) begin
      in_frame  <= !in_eof;
      skip_q    <= cur_skip;
      trunc_q   <= trunc_n;
      started_q <= started_n;
      sf_q      <= cur_sf;
      sel_q     <= cur_sel;
      start_q   <= cur_start;
      cnt_q     <= cnt_n;
      wr_ptr    <= drop_end ? cur_start : wr_next;
      if (sts_push) begin
        commit_ptr <= wr_next;
        done_ptr   <= wr_next;
      end else if (started_n && !in_eof) begin
        commit_ptr <= wr_next;
      end
    end
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxff_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int STS_DEPTH = 64,
  parameter int THR_UNIT = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(STS_DEPTH) + 1,
  localparam int SW = PW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_store_fwd,
  input  logic [1:0]    cfg_thr_sel,
  input  logic          cfg_fwd_err,
  input  logic          cfg_keep_csum,
  input  logic          cfg_flush_dis,
  input  logic          desc_unavail,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic          in_csum_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          sts_valid,
  input  logic          sts_ready,
  output logic [PW-1:0] sts_len,
  output logic          sts_err,
  output logic          sts_csum
);
  logic [PW-1:0] wr_ptr, commit_ptr, done_ptr, push_end, rd_ptr, w_len;
  logic          mem_we, w_push, w_err, w_csum;
  logic [AW-1:0] mem_addr;
  logic [8:0]    mem_wdata, rd_word;
  logic          rd_mid, flush_now, rd_fire, q_valid;
  logic [CW-1:0] sts_cnt;
  logic [SW-1:0] q_dout;

  rxff_wr_ctrl #(.DEPTH(DEPTH), .STS_DEPTH(STS_DEPTH), .THR_UNIT(THR_UNIT)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_csum_err(in_csum_err),
    .cfg_store_fwd(cfg_store_fwd), .cfg_thr_sel(cfg_thr_sel),
    .cfg_fwd_err(cfg_fwd_err), .cfg_keep_csum(cfg_keep_csum),
    .rd_ptr(rd_ptr), .sts_cnt(sts_cnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .commit_ptr(commit_ptr), .done_ptr(done_ptr), .push_end(push_end),
    .sts_push(w_push), .sts_len(w_len), .sts_err(w_err), .sts_csum(w_csum)
  );

  rxff_ram #(.DW(9), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_ptr[AW-1:0]), .rdata(rd_word)
  );

  rxff_sts_q #(.W(SW), .DEPTH(STS_DEPTH)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr(flush_now),
    .push(w_push), .din({w_len, w_err, w_csum}),
    .pop(sts_valid && sts_ready), .dout(q_dout), .valid(q_valid), .count(sts_cnt)
  );

  // flush only at a frame boundary of the reader
  assign flush_now = desc_unavail && !cfg_flush_dis && !rd_mid;
  assign out_valid = (rd_ptr != commit_ptr) && !flush_now;
  assign out_data  = rd_word[7:0];
  assign out_last  = rd_word[8];
  assign rd_fire   = out_valid && out_ready;
  assign sts_valid = q_valid && !flush_now;
  assign {sts_len, sts_err, sts_csum} = q_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      rd_mid <= 1'b0;
    end else if (flush_now) begin
      rd_ptr <= w_push ? push_end : done_ptr;
    end else if (rd_fire) begin
      rd_ptr <= rd_ptr + 1'b1;
      rd_mid <= !out_last;
    end
  end
endmodule

// File: rtl/rxff_chk.sv
module rxff_chk #(
  parameter int DEPTH = 2048,
  parameter int STS_DEPTH = 64,
  localparam int PW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(STS_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          sts_valid,
  input logic          sts_ready,
  input logic [PW-1:0] sts_len,
  input logic          sts_err,
  input logic          sts_csum,
  input logic          desc_unavail,
  input logic          flush_dis,
  input logic          rd_mid,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [CW-1:0] sts_cnt
);
  logic [PW-1:0] occ;
  logic          flush_req;
  assign occ       = wr_ptr - rd_ptr;
  assign flush_req = desc_unavail && !flush_dis;

  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush_req) |=>
      (flush_req || (out_valid && $stable(out_data) && $stable(out_last))));

  assert_sts_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_ready && !flush_req) |=>
      (flush_req || (sts_valid && $stable(sts_len) && $stable(sts_err) && $stable(sts_csum))));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !rd_mid) |=> !sts_valid);

  assert_sts_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sts_cnt <= CW'(STS_DEPTH));
endmodule

bind rx_frame_fifo rxff_chk #(.DEPTH(DEPTH), .STS_DEPTH(STS_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_len(sts_len),
  .sts_err(sts_err), .sts_csum(sts_csum),
  .desc_unavail(desc_unavail), .flush_dis(cfg_flush_dis), .rd_mid(rd_mid),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .sts_cnt(sts_cnt)
);

// File: tb/sim_rx_frame_fifo.sv
module sim_rx_frame_fifo;
  localparam int DEPTH = 64;
  localparam int STS_DEPTH = 4;
  localparam int THR_UNIT = 8;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_store_fwd = 1'b1, cfg_fwd_err = 1'b0, cfg_keep_csum = 1'b0, cfg_flush_dis = 1'b1;
  logic [1:0] cfg_thr_sel = 2'd0;
  logic desc_unavail = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0, in_csum_err = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_last, sts_valid, sts_err, sts_csum;
  logic out_ready = 1'b0, sts_ready = 1'b0;
  logic [7:0] out_data;
  logic [PW-1:0] sts_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_frame_fifo #(.DEPTH(DEPTH), .STS_DEPTH(STS_DEPTH), .THR_UNIT(THR_UNIT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_store_fwd(cfg_store_fwd), .cfg_thr_sel(cfg_thr_sel), .cfg_fwd_err(cfg_fwd_err),
    .cfg_keep_csum(cfg_keep_csum), .cfg_flush_dis(cfg_flush_dis), .desc_unavail(desc_unavail),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_csum_err(in_csum_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_len(sts_len),
    .sts_err(sts_err), .sts_csum(sts_csum)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive n beats of a frame with byte values base+idx
  task automatic send_seg(input logic [7:0] base, input int first, input int n,
                          input bit is_start, input bit is_end, input bit err, input bit csum);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = 8'(int'(base) + first + k);
      in_sof      = is_start && (k == 0);
      in_eof      = is_end && (k == n - 1);
      in_err      = in_eof && err;
      in_csum_err = in_eof && csum;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_csum_err = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] base, input int len, input bit err, input bit csum);
    send_seg(base, 0, len, 1'b1, 1'b1, err, csum);
  endtask

  // read one frame; the final byte is expected to equal last_val
  task automatic read_expect(input logic [7:0] base, input int len, input logic [7:0] last_val,
                             input string req);
    int bad = 0;
    int first_bad = -1;
    out_ready = 1'b1;
    for (int i = 0; i < len; i++) begin
      logic [7:0] ev;
      int w = 0;
      while (!out_valid && w < 100) begin @(negedge clk); w++; end
      ev = (i == len - 1) ? last_val : 8'(int'(base) + i);
      if (!out_valid || out_data != ev || out_last != (i == len - 1)) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(bad == 0, req, first_bad, -1);
  endtask

  task automatic read_sts(input int len, input bit err, input bit csum, input string req);
    int w = 0;
    while (!sts_valid && w < 100) begin @(negedge clk); w++; end
    chk(sts_valid && int'(sts_len) == len && sts_err == err && sts_csum == csum, req,
        int'({sts_valid, sts_err, sts_csum}) * 1000 + int'(sts_len),
        int'({1'b1, err, csum}) * 1000 + len);
    sts_ready = 1'b1;
    @(negedge clk);
    sts_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    repeat (2) @(negedge clk);
    chk(!out_valid && !sts_valid, req, int'({out_valid, sts_valid}), 0);
  endtask

  task automatic cfg_default();
    cfg_store_fwd = 1'b1; cfg_thr_sel = 2'd0; cfg_fwd_err = 1'b0;
    cfg_keep_csum = 1'b0; cfg_flush_dis = 1'b1; desc_unavail = 1'b0;
  endtask

  task automatic t_reset();
    chk(!out_valid && !sts_valid, "R1 reset outputs", int'({out_valid, sts_valid}), 0);
  endtask

  task automatic t_store_fwd();
    send_seg(8'h10, 0, 9, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(!out_valid, "R2 nothing offered before end byte", int'(out_valid), 0);
    send_seg(8'h10, 9, 1, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == 8'h10, "R13 byte held under back-pressure", int'(out_data), 'h10);
    chk(sts_valid && int'(sts_len) == 10, "R12 status held under back-pressure", int'(sts_len), 10);
    read_expect(8'h10, 10, 8'h19, "R2 store-and-forward data order");
    read_sts(10, 1'b0, 1'b0, "R12 good frame status");
    expect_idle("R2 buffer empty after frame");
  endtask

  task automatic t_cut_through();
    cfg_store_fwd = 1'b0; cfg_thr_sel = 2'd1;  // 16 bytes
    send_seg(8'h20, 0, 15, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(!out_valid, "R3 below threshold", int'(out_valid), 0);
    send_seg(8'h20, 15, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(out_valid, "R3 threshold reached", int'(out_valid), 1);
    send_seg(8'h20, 16, 4, 1'b0, 1'b1, 1'b1, 1'b0);
    read_expect(8'h20, 20, 8'h33, "R7 started frame delivered");
    read_sts(20, 1'b1, 1'b0, "R7 started frame marked errored");
    cfg_thr_sel = 2'd0;
    send_frame(8'h30, 5, 1'b1, 1'b0);
    expect_idle("R4 short cut-through error frame dropped");
    send_frame(8'h38, 5, 1'b0, 1'b0);
    read_expect(8'h38, 5, 8'h3c, "R4 space reused in cut-through");
    read_sts(5, 1'b0, 1'b0, "R4 next frame status");
    cfg_default();
  endtask

  task automatic t_drop_filters();
    send_frame(8'h40, 6, 1'b1, 1'b0);
    expect_idle("R4 error frame dropped");
    send_frame(8'h50, 6, 1'b0, 1'b0);
    read_expect(8'h50, 6, 8'h55, "R4 following frame intact");
    read_sts(6, 1'b0, 1'b0, "R4 following frame status");
    cfg_keep_csum = 1'b1;
    send_frame(8'h60, 7, 1'b0, 1'b1);
    read_expect(8'h60, 7, 8'h66, "R5 checksum-only frame kept");
    read_sts(7, 1'b0, 1'b1, "R5 checksum mark");
    send_frame(8'h68, 4, 1'b1, 1'b1);
    expect_idle("R5 both errors still dropped");
    cfg_keep_csum = 1'b0;
    send_frame(8'h70, 4, 1'b0, 1'b1);
    expect_idle("R5 checksum frame dropped when not spared");
    cfg_fwd_err = 1'b1;
    send_frame(8'h78, 5, 1'b1, 1'b0);
    read_expect(8'h78, 5, 8'h7c, "R6 error frame forwarded");
    read_sts(5, 1'b1, 1'b0, "R6 error mark");
    cfg_default();
  endtask

  task automatic t_overflow();
    cfg_fwd_err = 1'b1;
    send_frame(8'h00, 80, 1'b0, 1'b0);
    read_expect(8'h00, 64, 8'h4f, "R8 truncated frame contents");
    read_sts(64, 1'b1, 1'b0, "R8 truncated frame status");
    expect_idle("R8 nothing after truncated frame");
    cfg_default();
  endtask

  task automatic t_flush();
    send_frame(8'h80, 4, 1'b0, 1'b0);
    send_frame(8'h90, 4, 1'b0, 1'b0);
    desc_unavail = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid && sts_valid && out_data == 8'h80, "R10 flush disabled keeps frames",
        int'(out_data), 'h80);
    cfg_flush_dis = 1'b0;
    @(negedge clk);
    desc_unavail = 1'b0; cfg_flush_dis = 1'b1;
    chk(!out_valid && !sts_valid, "R9 flush removes frames", int'({out_valid, sts_valid}), 0);
    send_frame(8'ha0, 3, 1'b0, 1'b0);
    read_expect(8'ha0, 3, 8'ha2, "R9 frame after flush");
    read_sts(3, 1'b0, 1'b0, "R9 status after flush");
    expect_idle("R9 no stale status");
  endtask

  task automatic t_sts_full();
    for (int f = 0; f < 5; f++) send_frame(8'(16 * (f + 1)), 3, 1'b0, 1'b0);
    for (int f = 0; f < 4; f++) begin
      read_expect(8'(16 * (f + 1)), 3, 8'(16 * (f + 1) + 2), "R11 queued frame");
      read_sts(3, 1'b0, 1'b0, "R11 queued status");
    end
    expect_idle("R11 fifth frame discarded");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_store_fwd();
    t_cut_through();
    t_drop_filters();
    t_overflow();
    t_flush();
    t_sts_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule